// File: doc/BRIEF.md
# Horizontal Sync Polarity Normalizer and Regenerator

This block sits in the pixel clock domain and takes a raw horizontal sync whose polarity is not known in advance. It synchronizes the input. It then works out which level is the active one, either by measuring the line itself or by following a manual setting. From that it builds an active-high internal sync. The block rebuilds the output sync from the leading edge of that internal sync. The output pulse has a programmable width counted in pixel clocks and a programmable output polarity, and it is registered so that it lines up with the output data clock.

A second output carries the normalized sync to the clock-recovery loop. A coast input blanks this reference and stops regeneration while the incoming sync cannot be trusted, for example during equalization pulses or when pulses are missing. A configuration bit can switch the coast function off completely.

Top module: `hsync_regen`

## Requirements
- R1: After reset, `sync_out` sits at its inactive level, `ref_out` is 0 and the detected polarity is active low. An active-low input is therefore regenerated on its falling edges before any detection has taken place.
- R2: With `cfg_auto_pol`=1, a line is the span between two rising edges of the synchronized input. The level held for fewer samples in a line is taken as active, and a tie counts as active low. The detected polarity changes only after two consecutive complete lines give the same result.
- R3: With `cfg_auto_pol`=0, `cfg_man_pol` selects the input polarity (1 = active high, 0 = active low). A setting that does not match the input makes the block treat the inactive level as the sync.
- R4: `cfg_out_pol`=1 makes `sync_out` active high; 0 makes it active low.
- R5: A regenerated pulse lasts `cfg_width`+1 pixel clocks, so a value of 0 gives a one-clock pulse.
- R6: A leading edge of the input sync shows on `sync_out` and `ref_out` at the third rising clock edge after the input changes (two synchronizer stages plus one output register).
- R7: A leading edge that arrives while a pulse is active reloads the width counter, so the pulse ends `cfg_width`+1 clocks after that newer edge.
- R8: `ref_out` is the normalized active-high sync with the same latency as R6, and it is 0 in any cycle that follows a cycle with coast in effect.
- R9: While `coast_in`=1 and `cfg_coast_en`=1, leading edges start no pulse. Regeneration resumes on the first leading edge after coast ends; an input already at its active level when coast ends starts nothing.
- R10: With `cfg_coast_en`=0, `coast_in` has no effect on `sync_out` or `ref_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_in | input | 1 | Raw horizontal sync, unknown polarity |
| coast_in | input | 1 | Coast request, synchronous to clk |
| cfg_auto_pol | input | 1 | 1 = detect input polarity, 0 = use cfg_man_pol |
| cfg_man_pol | input | 1 | Manual input polarity, 1 = active high |
| cfg_out_pol | input | 1 | Output polarity, 1 = active high |
| cfg_coast_en | input | 1 | 1 = coast_in is honoured |
| cfg_width | input | WID_W | Output pulse width minus one, in pixel clocks |
| sync_out | output | 1 | Regenerated sync |
| ref_out | output | 1 | Gated active-high sync reference for the clock-recovery loop |

## Verification
The bench uses the default parameters: a two-stage synchronizer, an 8-bit width field and 12-bit line counters. The bench runs 40-clock lines with a 6-clock sync and widths up to 10. These sizes let a single line hold the full three-clock latency, the longest pulse and a retriggered pulse of 15 clocks. They are also short enough for a line of five to complete the two-line agreement rule and show the polarity change well before the window that is measured. Manual settings that do not match the input move the pulse start from clock 2 to clock 8 of the line and raise the reference count from 6 to 34. This makes an inverted normalization plain to see at the ports.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;
endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= {st_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/hsr_poldet.sv
module hsr_poldet
  import hsr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output pol_e det
);
  logic             raw_q;
  logic [CNT_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic             started_q, started_n;
  logic             cvld_q, cvld_n;
  pol_e             cand_q, cand_n, det_q, det_n;
  pol_e             line_pol;
  logic             rise;

  assign rise     = raw & ~raw_q;
  assign line_pol = (hi_q < lo_q) ? POL_HIGH : POL_LOW;

  always_comb begin
    hi_n      = hi_q;
    lo_n      = lo_q;
    started_n = started_q;
    cvld_n    = cvld_q;
    cand_n    = cand_q;
    det_n     = det_q;
    if (rise) begin
      hi_n      = {{(CNT_W-1){1'b0}}, 1'b1};
      lo_n      = '0;
      started_n = 1'b1;
      if (started_q) begin
        cand_n = line_pol;
        cvld_n = 1'b1;
        if (cvld_q && (cand_q == line_pol)) det_n = line_pol;
      end
    end else if (raw) begin
      if (hi_q != '1) hi_n = hi_q + 1'b1;
    end else begin
      if (lo_q != '1) lo_n = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      started_q <= 1'b0;
      cvld_q    <= 1'b0;
      cand_q    <= POL_LOW;
      det_q     <= POL_LOW;
    end else begin
      raw_q     <= raw;
      hi_q      <= hi_n;
      lo_q      <= lo_n;
      started_q <= started_n;
      cvld_q    <= cvld_n;
      cand_q    <= cand_n;
      if (rise) det_q <= det_n;
    end
  end

  assign det = det_q;
endmodule

// File: rtl/hsr_pulse.sv
module hsr_pulse #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm,
  input  logic             coast,
  input  logic [WID_W-1:0] width,
  output logic             lead,
  output logic             active,
  output logic             ref_q
);
  logic             norm_q;
  logic             act_q, act_n;
  logic [WID_W-1:0] cnt_q, cnt_n;
  logic             ref_n;

  assign lead = norm & ~norm_q;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (lead && !coast) begin
      act_n = 1'b1;
      cnt_n = width;
    end else if (act_q) begin
      if (cnt_q == '0) act_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
    ref_n = norm & ~coast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= 1'b1;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      ref_q  <= 1'b0;
    end else begin
      norm_q <= norm;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      ref_q  <= ref_n;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WID_W       = 8,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             coast_in,
  input  logic             cfg_auto_pol,
  input  logic             cfg_man_pol,
  input  logic             cfg_out_pol,
  input  logic             cfg_coast_en,
  input  logic [WID_W-1:0] cfg_width,
  output logic             sync_out,
  output logic             ref_out
);
  logic rst_n_s;
  logic raw;
  pol_e det;
  pol_e pol_use;
  logic norm;
  logic coast_eff;
  logic lead;
  logic pulse_act;

  hsr_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  hsr_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_n_s), .d(sync_in), .q(raw)
  );

  hsr_poldet #(.CNT_W(CNT_W)) u_poldet (
    .clk(clk), .rst_n(rst_n_s), .raw(raw), .det(det)
  );

  assign pol_use   = cfg_auto_pol ? det : (cfg_man_pol ? POL_HIGH : POL_LOW);
  assign norm      = (pol_use == POL_HIGH) ? raw : ~raw;
  assign coast_eff = cfg_coast_en & coast_in;

  hsr_pulse #(.WID_W(WID_W)) u_pulse (
    .clk(clk), .rst_n(rst_n_s), .norm(norm), .coast(coast_eff),
    .width(cfg_width), .lead(lead), .active(pulse_act), .ref_q(ref_out)
  );

  assign sync_out = cfg_out_pol ? pulse_act : ~pulse_act;
endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk
  import hsr_pkg::*;
#(
  parameter int WID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coast_in,
  input logic             cfg_coast_en,
  input logic [WID_W-1:0] cfg_width,
  input logic             lead,
  input logic             pulse_act,
  input logic             ref_out,
  input logic             raw,
  input pol_e             det
);
  logic coast;
  assign coast = cfg_coast_en & coast_in;

  assert_coast_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coast |=> !ref_out);

  assert_coast_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coast && !pulse_act) |=> !pulse_act);

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && !coast) |=> pulse_act);

  assert_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_width == '0 && pulse_act && !lead) |=> !pulse_act);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_act && !lead) |=> !pulse_act);

  assert_det_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (det != $past(det)) |-> ($past(raw) && !$past(raw, 2)));
endmodule

bind hsync_regen hsync_regen_chk #(.WID_W(WID_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .coast_in(coast_in), .cfg_coast_en(cfg_coast_en),
  .cfg_width(cfg_width), .lead(lead), .pulse_act(pulse_act), .ref_out(ref_out),
  .raw(raw), .det(det)
);

// File: tb/sim_hsync_regen.sv
module sim_hsync_regen;
  localparam int PERIOD = 10;
  localparam int WID_W  = 8;
  localparam int LINE   = 40;
  localparam int SYNCW  = 6;
  // {in_pol, auto, man, out_pol, width[3:0], first_active[5:0], ref_count[5:0]}
  localparam logic [19:0] VEC [0:6] = '{
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd3, 6'd2, 6'd6},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 6'd2, 6'd6},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd7, 6'd2, 6'd6},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd5, 6'd2, 6'd6},
    {1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 6'd2, 6'd6},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 6'd8, 6'd34},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 6'd8, 6'd34}
  };

  logic clk = 1'b0;
  logic rst_n, sync_in, coast_in;
  logic cfg_auto_pol, cfg_man_pol, cfg_out_pol, cfg_coast_en;
  logic [WID_W-1:0] cfg_width;
  logic sync_out, ref_out;
  int n_tests = 0;
  int n_fail  = 0;
  int n_act, n_ref, first_act;

  always #(PERIOD/2) clk = ~clk;

  hsync_regen u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .coast_in(coast_in),
    .cfg_auto_pol(cfg_auto_pol), .cfg_man_pol(cfg_man_pol),
    .cfg_out_pol(cfg_out_pol), .cfg_coast_en(cfg_coast_en),
    .cfg_width(cfg_width), .sync_out(sync_out), .ref_out(ref_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic c);
    @(negedge clk);
    sync_in  = s;
    coast_in = c;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic idle, input logic a, input logic m,
                          input logic o, input logic ce, input int w);
    @(negedge clk);
    rst_n = 1'b0; sync_in = idle; coast_in = 1'b0;
    cfg_auto_pol = a; cfg_man_pol = m; cfg_out_pol = o; cfg_coast_en = ce;
    cfg_width = WID_W'(w);
    for (int i = 0; i < 3; i++) tick(idle, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) tick(idle, 1'b0);
  endtask

  // one line: SYNCW clocks active, then inactive; measures the window
  task automatic run_line(input logic ip);
    n_act = 0; n_ref = 0; first_act = -1;
    for (int i = 0; i < LINE; i++) begin
      tick((i < SYNCW) ? ip : ~ip, 1'b0);
      if (sync_out == cfg_out_pol) begin
        n_act++;
        if (first_act < 0) first_act = i;
      end
      if (ref_out) n_ref++;
    end
  endtask

  task automatic run_seq(input logic [7:0] pat [], input logic c);
    n_act = 0; n_ref = 0;
    foreach (pat[i]) begin
      tick(pat[i][0], c);
      if (sync_out == cfg_out_pol) n_act++;
      if (ref_out) n_ref++;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat [];
    rst_n = 1'b0; sync_in = 1'b0; coast_in = 1'b0;
    cfg_auto_pol = 1'b1; cfg_man_pol = 1'b0; cfg_out_pol = 1'b1;
    cfg_coast_en = 1'b1; cfg_width = '0;

    // vector table: five lines, measure the last
    for (int v = 0; v < 7; v++) begin
      logic [19:0] e;
      e = VEC[v];
      do_reset(~e[19], e[18], e[17], e[16], 1'b1, int'(e[15:12]));
      for (int l = 0; l < 5; l++) run_line(e[19]);
      check(n_act == int'(e[15:12]) + 1, "R5 width / R4 polarity", n_act, int'(e[15:12]) + 1);
      check(first_act == int'(e[11:6]), "R6 latency / R2 R3 edge choice", first_act, int'(e[11:6]));
      check(n_ref == int'(e[5:0]), "R8 reference / R2 R3 normalization", n_ref, int'(e[5:0]));
    end

    // R1: reset levels, default active-low polarity
    do_reset(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2);
    check(sync_out == 1'b0, "R1 sync_out inactive", int'(sync_out), 0);
    check(ref_out == 1'b0, "R1 ref_out low", int'(ref_out), 0);
    run_line(1'b0);
    check(first_act == 2, "R1 active-low before detection", first_act, 2);

    // R2: one agreeing line is not enough
    do_reset(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3);
    run_line(1'b1);
    run_line(1'b1);
    check(n_ref == 34, "R2 no change after one line", n_ref, 34);
    check(first_act == 8, "R2 old polarity edge", first_act, 8);
    run_line(1'b1); run_line(1'b1); run_line(1'b1);
    check(n_ref == 6, "R2 change after two lines", n_ref, 6);

    // R7: retrigger while active
    do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10);
    pat = new[30];
    foreach (pat[i]) pat[i] = (i == 0 || i == 4) ? 8'd1 : 8'd0;
    run_seq(pat, 1'b0);
    check(n_act == 15, "R7 retrigger length", n_act, 15);

    // R9: coast masks edges and reference
    do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2);
    pat = new[13];
    foreach (pat[i]) pat[i] = (i >= 3 && i < 8) ? 8'd1 : 8'd0;
    run_seq(pat, 1'b1);
    check(n_act == 0, "R9 no pulse under coast", n_act, 0);
    check(n_ref == 0, "R8 reference blanked by coast", n_ref, 0);
    pat = new[4];
    foreach (pat[i]) pat[i] = 8'd1;
    run_seq(pat, 1'b1);
    pat = new[6];
    foreach (pat[i]) pat[i] = 8'd1;
    run_seq(pat, 1'b0);
    check(n_act == 0, "R9 level at coast end starts nothing", n_act, 0);
    pat = new[12];
    foreach (pat[i]) pat[i] = (i == 3) ? 8'd1 : 8'd0;
    run_seq(pat, 1'b0);
    check(n_act == 3, "R9 resume on next edge", n_act, 3);

    // R10: coast disabled
    do_reset(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2);
    pat = new[12];
    foreach (pat[i]) pat[i] = (i < 3) ? 8'd1 : 8'd0;
    run_seq(pat, 1'b1);
    check(n_act == 3, "R10 pulse with coast disabled", n_act, 3);
    check(n_ref == 3, "R10 reference with coast disabled", n_ref, 3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule